// File: doc/BRIEF.md
# Per-Processor Timer Bank with Wide User Counter

This block holds one system timer and a parameterised number of processor timers (up to sixteen). Each timer owns its own register window and its own interrupt line. By default every timer is an interval timer: a 22-bit count field advances on each shared tick and is compared against a programmable limit. When the count meets the limit, the timer raises its reached flag and its interrupt. A limit of zero makes the timer run freely with no match.

A mode register in the system timer's window holds one bit per processor timer. Setting a bit turns that processor timer into a 54-bit user counter. The same two register offsets then become the upper and lower words of a loadable count. A start/stop bit gates the count, and the timer never interrupts. Each timer is controlled by a three-state machine: `TS_COUNTER`, `TS_USER_RUN` and `TS_USER_HALT`. The transitions are named as follows:
- *enter_user_run*: mode bit set while the run bit is 1.
- *enter_user_halt*: mode bit set while the run bit is 0.
- *leave_user*: mode bit cleared, from either user state.
- *stop*: status write of 0 in `TS_USER_RUN`.
- *start*: status write of 1 in `TS_USER_HALT`.

Registers are word-indexed by `bus_reg`: index 0 = limit / upper word, 1 = count / lower word, 2 = limit without count reset, 3 = status (run bit), 4 = mode (system window only). `bus_win` 0 selects the system timer and `bus_win` k selects processor timer k. Reads return data in the same cycle. Their side effects and all writes take effect at the next clock edge.

Top module: `ctrbank_top`

## Requirements
- R1: After reset, the mode register reads 0, every interrupt is low, a processor timer's status reads 1, and every timer is in counter mode with limit 0.
- R2: Mode register (system window, index 4): bit i selects user mode for processor timer i+1. Bits at or above NCPU read 0 and have no effect. A write to index 4 in a processor window is ignored.
- R3: In user mode, a read of index 0 returns {reached, count[53:23]} and a read of index 1 returns {count[22:0], 9'b0}.
- R4: In user mode, a write of index 0 loads count[53:23] from wdata[30:0]. A write of index 1 loads count[22:0] from wdata[31:9]. Either write clears reached, and counting continues from the loaded value.
- R5: A running user counter adds one unit (0x200 in register terms) per tick. A halted one holds its value.
- R6: A user counter at its maximum (register value 0x7FFFFFFFFFFFFE00) wraps to zero on the next tick and sets reached (bit 31 of index 0).
- R7: Bit 0 of a write to index 3 stores the run bit and, in user mode, starts (1) or stops (0) the counter. A read of index 3 returns the run bit for processor timers and 0 for the system timer.
- R8: A timer in user mode never asserts its interrupt.
- R9: On entering user mode, the interrupt drops, the limit becomes 0x7FFFFE00, and the count keeps its value. The count then advances only if the run bit is 1.
- R10: On leaving user mode, the timer counts on every tick whatever its run bit holds, and the run bit keeps its stored value.
- R11: In counter mode, a write of index 0 sets the limit to wdata[30:9], clears the count, reached and the interrupt. The tick that would make the count equal a nonzero limit instead clears the count and sets reached and the interrupt. A limit of 0 counts freely with no match.
- R12: In counter mode, a read of index 0 returns the limit (wdata & 0x7FFFFE00) and clears reached and the interrupt. A read of index 1 returns {reached, count[21:0], 9'b0}.
- R13: A write of index 2 sets the limit without touching the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Shared count enable, one unit per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (for read side effects) |
| bus_win | input | WIN_W | Window select: 0 system, k processor timer k |
| bus_reg | input | 3 | Word index within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| irq | output | NCPU+1 | Interrupt per timer, bit 0 system |

## Verification
The bench builds the bank with NCPU = 3. This lets a mode write carry ones in bits 3 to 31, so the bits beyond the processor count can be shown to read back as zero and to leave all timers unchanged. Three processor timers let one sit halted in user mode, another count in counter mode and a third take the random loads side by side, while the system timer runs free underneath. Loads placed just below the 54-bit maximum bring the carry between the two words and the wrap into reach within a few ticks.

// File: rtl/ctrbank_pkg.sv
package ctrbank_pkg;
    localparam int WORD_W = 32;
    localparam int SUB_W  = 9;
    localparam int HI_W   = WORD_W - 1;
    localparam int LO_W   = WORD_W - SUB_W;
    localparam int CNT_W  = HI_W + LO_W;
    localparam int LIM_W  = WORD_W - 1 - SUB_W;
    localparam int REG_W  = 3;

    typedef enum logic [1:0] {
        TS_COUNTER   = 2'd0,
        TS_USER_RUN  = 2'd1,
        TS_USER_HALT = 2'd2
    } tstate_e;

    localparam logic [REG_W-1:0] RG_HIGH  = 3'd0;
    localparam logic [REG_W-1:0] RG_LOW   = 3'd1;
    localparam logic [REG_W-1:0] RG_LIMNR = 3'd2;
    localparam logic [REG_W-1:0] RG_RUN   = 3'd3;
    localparam logic [REG_W-1:0] RG_MODE  = 3'd4;
endpackage

// File: rtl/ctrbank_decode.sv
module ctrbank_decode
    import ctrbank_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int WIN_W = 3
) (
    input  logic                         bus_wr_i,
    input  logic                         bus_rd_i,
    input  logic [WIN_W-1:0]             bus_win_i,
    input  logic [REG_W-1:0]             bus_reg_i,
    input  logic [NCPU:0][WORD_W-1:0]    slice_rdata_i,
    input  logic [NCPU:0]                user_all_i,
    output logic [NCPU:0]                wr_hit_o,
    output logic [NCPU:0]                rd_hit_o,
    output logic                         mode_wr_o,
    output logic [WORD_W-1:0]            rdata_o
);
    logic win_ok;
    assign win_ok = int'(bus_win_i) <= NCPU;

    for (genvar g = 0; g <= NCPU; g++) begin : g_hit
        assign wr_hit_o[g] = bus_wr_i && (bus_win_i == WIN_W'(g));
        assign rd_hit_o[g] = bus_rd_i && (bus_win_i == WIN_W'(g));
    end

    assign mode_wr_o = bus_wr_i && (bus_win_i == '0) && (bus_reg_i == RG_MODE);

    always_comb begin
        rdata_o = '0;
        if ((bus_win_i == '0) && (bus_reg_i == RG_MODE))
            rdata_o = WORD_W'(user_all_i >> 1);
        else if (win_ok)
            rdata_o = slice_rdata_i[bus_win_i];
    end
endmodule

// File: rtl/ctrbank_slice.sv
module ctrbank_slice
    import ctrbank_pkg::*;
#(
    parameter bit IS_SYS = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [REG_W-1:0]   reg_i,
    input  logic [WORD_W-1:0]  wdata_i,
    input  logic               mode_wr_i,
    input  logic               mode_val_i,
    output logic [WORD_W-1:0]  rdata_o,
    output logic               irq_o,
    output logic               user_o
);
    tstate_e            state_q, state_d;
    logic               run_q, run_d;
    logic [LIM_W-1:0]   lim_q, lim_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic               reached_q, reached_d;
    logic               irq_q, irq_d;
    logic               is_user, counting, enter_user;
    logic [LIM_W-1:0]   ctr_next;

    assign is_user  = (state_q != TS_COUNTER);
    assign counting = (state_q == TS_COUNTER) || (state_q == TS_USER_RUN);
    assign ctr_next = cnt_q[LIM_W-1:0] + LIM_W'(1);

    // state transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_COUNTER: begin
                if (mode_wr_i && mode_val_i)
                    state_d = run_q ? TS_USER_RUN : TS_USER_HALT;     // enter_user_run / enter_user_halt
            end
            TS_USER_RUN: begin
                if (mode_wr_i && !mode_val_i)
                    state_d = TS_COUNTER;                             // leave_user
                else if (wr_i && reg_i == RG_RUN && !wdata_i[0])
                    state_d = TS_USER_HALT;                           // stop
            end
            TS_USER_HALT: begin
                if (mode_wr_i && !mode_val_i)
                    state_d = TS_COUNTER;                             // leave_user
                else if (wr_i && reg_i == RG_RUN && wdata_i[0])
                    state_d = TS_USER_RUN;                            // start
            end
            default: state_d = TS_COUNTER;
        endcase
    end

    assign enter_user = (state_q == TS_COUNTER) && (state_d != TS_COUNTER);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TS_COUNTER;
        else        state_q <= state_d;
    end

    // datapath next values
    always_comb begin
        cnt_d     = cnt_q;
        lim_d     = lim_q;
        reached_d = reached_q;
        irq_d     = irq_q;
        run_d     = run_q;

        if (rd_i && reg_i == RG_HIGH && !is_user) begin
            reached_d = 1'b0;
            irq_d     = 1'b0;
        end

        if (tick && counting) begin
            if (is_user) begin
                if (&cnt_q) begin
                    cnt_d     = '0;
                    reached_d = 1'b1;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end else if (lim_q != '0 && ctr_next == lim_q) begin
                cnt_d     = '0;
                reached_d = 1'b1;
                irq_d     = 1'b1;
            end else begin
                cnt_d = CNT_W'(ctr_next);
            end
        end

        if (enter_user) begin
            irq_d = 1'b0;
            lim_d = '1;
        end

        if (wr_i) begin
            unique case (reg_i)
                RG_HIGH: begin
                    if (is_user) begin
                        cnt_d     = {wdata_i[HI_W-1:0], cnt_q[LO_W-1:0]};
                        reached_d = 1'b0;
                    end else begin
                        lim_d     = wdata_i[WORD_W-2:SUB_W];
                        cnt_d     = '0;
                        reached_d = 1'b0;
                        irq_d     = 1'b0;
                    end
                end
                RG_LOW: begin
                    if (is_user) begin
                        cnt_d     = {cnt_q[CNT_W-1:LO_W], wdata_i[WORD_W-1:SUB_W]};
                        reached_d = 1'b0;
                    end
                end
                RG_LIMNR: lim_d = wdata_i[WORD_W-2:SUB_W];
                RG_RUN: begin
                    if (!IS_SYS) run_d = wdata_i[0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            lim_q     <= '0;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
            run_q     <= 1'b1;
        end else begin
            cnt_q     <= cnt_d;
            lim_q     <= lim_d;
            reached_q <= reached_d;
            irq_q     <= irq_d;
            run_q     <= run_d;
        end
    end

    // outputs
    always_comb begin
        rdata_o = '0;
        unique case (reg_i)
            RG_HIGH:  rdata_o = is_user ? {reached_q, cnt_q[CNT_W-1:LO_W]}
                                        : {1'b0, lim_q, {SUB_W{1'b0}}};
            RG_LOW:   rdata_o = is_user ? {cnt_q[LO_W-1:0], {SUB_W{1'b0}}}
                                        : {reached_q, cnt_q[LIM_W-1:0], {SUB_W{1'b0}}};
            RG_RUN:   rdata_o = IS_SYS ? '0 : {{(WORD_W-1){1'b0}}, run_q};
            default:  rdata_o = '0;
        endcase
    end

    assign irq_o  = irq_q;
    assign user_o = is_user;

    AST_USER_QUIET: assert property (@(posedge clk) disable iff (!rst_n) is_user |-> !irq_o); // R8
    AST_RUN_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (state_q == TS_USER_RUN) |-> run_q); // R7
    AST_HALT_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (state_q == TS_USER_HALT) |-> !run_q); // R7
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_USER_HALT && !wr_i && !mode_wr_i) |=> $stable(cnt_q)); // R5
    AST_USER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_USER_RUN && tick && !wr_i && !mode_wr_i && !(&cnt_q))
        |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R5
    AST_USER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_USER_RUN && tick && !wr_i && !mode_wr_i && (&cnt_q))
        |=> (cnt_q == '0 && reached_q)); // R6
    AST_ENTER_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_COUNTER && mode_wr_i && mode_val_i) |=> (!irq_o && (&lim_q))); // R9
    AST_LEAVE_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (is_user && mode_wr_i && !mode_val_i) |=> (state_q == TS_COUNTER)); // R10
endmodule

// File: rtl/ctrbank_top.sv
module ctrbank_top
    import ctrbank_pkg::*;
#(
    parameter  int NCPU  = 4,
    localparam int WIN_W = $clog2(NCPU + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [WIN_W-1:0]   bus_win,
    input  logic [REG_W-1:0]   bus_reg,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic [NCPU:0]      irq
);
    logic [NCPU:0]              wr_hit, rd_hit, user_all;
    logic [NCPU:0][WORD_W-1:0]  slice_rdata;
    logic                       mode_wr;

    ctrbank_decode #(.NCPU(NCPU), .WIN_W(WIN_W)) u_decode (
        .bus_wr_i      (bus_wr),
        .bus_rd_i      (bus_rd),
        .bus_win_i     (bus_win),
        .bus_reg_i     (bus_reg),
        .slice_rdata_i (slice_rdata),
        .user_all_i    (user_all),
        .wr_hit_o      (wr_hit),
        .rd_hit_o      (rd_hit),
        .mode_wr_o     (mode_wr),
        .rdata_o       (bus_rdata)
    );

    for (genvar g = 0; g <= NCPU; g++) begin : g_tmr
        if (g == 0) begin : g_sys
            ctrbank_slice #(.IS_SYS(1'b1)) u_slice (
                .clk        (clk),
                .rst_n      (rst_n),
                .tick       (tick),
                .wr_i       (wr_hit[g]),
                .rd_i       (rd_hit[g]),
                .reg_i      (bus_reg),
                .wdata_i    (bus_wdata),
                .mode_wr_i  (1'b0),
                .mode_val_i (1'b0),
                .rdata_o    (slice_rdata[g]),
                .irq_o      (irq[g]),
                .user_o     (user_all[g])
            );
        end else begin : g_cpu
            ctrbank_slice #(.IS_SYS(1'b0)) u_slice (
                .clk        (clk),
                .rst_n      (rst_n),
                .tick       (tick),
                .wr_i       (wr_hit[g]),
                .rd_i       (rd_hit[g]),
                .reg_i      (bus_reg),
                .wdata_i    (bus_wdata),
                .mode_wr_i  (mode_wr),
                .mode_val_i (bus_wdata[g-1]),
                .rdata_o    (slice_rdata[g]),
                .irq_o      (irq[g]),
                .user_o     (user_all[g])
            );
        end
    end

    AST_MODE_WIN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_win != '0 && bus_reg == RG_MODE) |=> $stable(user_all)); // R2
    AST_SYS_NEVER_USER: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !user_all[0]); // R2
endmodule

// File: tb/ctrbank_top_test.sv
`timescale 1ns/1ps
module ctrbank_top_test;
    localparam int NCPU = 3;
    localparam int WW   = $clog2(NCPU + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [WW-1:0] bus_win = '0;
    logic [2:0] bus_reg = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCPU:0] irq;

    int total = 0;
    int bad = 0;

    ctrbank_top #(.NCPU(NCPU)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_win(bus_win), .bus_reg(bus_reg), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int w, input int r, input logic [31:0] d);
        @(negedge clk);
        bus_win = WW'(w); bus_reg = 3'(r); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int w, input int r, output logic [31:0] d);
        @(negedge clk);
        bus_win = WW'(w); bus_reg = 3'(r); bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    // model of a running user counter: load + n units, 54-bit wrap
    function automatic logic [63:0] user_model(input logic [30:0] hi, input logic [22:0] lo, input int n);
        logic [54:0] s;
        s = {1'b0, hi, lo} + 55'(n);
        return {s[54], s[53:23], s[22:0], 9'b0};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [63:0] e;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", 32'(irq), 32'h0);
        rd(0, 4, d); chk("R1 mode", d, 32'h0);
        rd(1, 3, d); chk("R1 run", d, 32'h1);
        rd(0, 3, d); chk("R7 sys status", d, 32'h0);

        // R11 free-run system timer, limit 0
        ticks(5);
        rd(0, 1, d); chk("R11 freerun count", d, 32'h0000_0A00);
        chk("R11 freerun irq", 32'(irq[0]), 32'h0);

        // R11/R12 counter mode with limit 5 on timer 2
        wr(2, 0, 32'h0000_0A00);
        ticks(3);
        rd(2, 1, d); chk("R12 count read", d, 32'h0000_0600);
        ticks(2);
        chk("R11 expiry irq", 32'(irq[2]), 32'h1);
        rd(2, 1, d); chk("R12 reached read", d, 32'h8000_0000);
        rd(2, 0, d); chk("R12 limit read", d, 32'h0000_0A00);
        chk("R12 read clears irq", 32'(irq[2]), 32'h0);
        rd(2, 1, d); chk("R12 reached cleared", d, 32'h0);

        // R13 limit change without count reset
        wr(2, 2, 32'h0000_1000);
        ticks(3);
        rd(2, 1, d); chk("R13 count kept", d, 32'h0000_0600);
        wr(2, 2, 32'h0000_0800);
        ticks(1);
        chk("R13 new limit hit", 32'(irq[2]), 32'h1);

        // R2 mode register, bits beyond NCPU ignored
        wr(0, 4, 32'hFFFF_FFFA);
        rd(0, 4, d); chk("R2 mode bits", d, 32'h2);
        chk("R9 irq dropped on entry", 32'(irq[2]), 32'h0);
        wr(1, 4, 32'h7);
        rd(0, 4, d); chk("R2 cpu window ignored", d, 32'h2);
        wr(0, 4, 32'h0);
        rd(0, 4, d); chk("R2 mode cleared", d, 32'h0);

        // R10 run bit stored in counter mode, counter still runs
        wr(1, 0, 32'h0);
        wr(1, 3, 32'h0);
        rd(1, 3, d); chk("R7 run stored", d, 32'h0);
        ticks(2);
        rd(1, 1, d); chk("R10 counter ignores run", d, 32'h0000_0400);

        // R9 enter user mode halted
        wr(0, 4, 32'h1);
        chk("R8 user irq low", 32'(irq[1]), 32'h0);
        rd(1, 0, d); chk("R3 upper word", d, 32'h0);
        rd(1, 1, d); chk("R9 count kept", d, 32'h0000_0400);
        ticks(4);
        rd(1, 1, d); chk("R9 halted holds", d, 32'h0000_0400);
        wr(1, 3, 32'h1);
        ticks(3);
        rd(1, 1, d); chk("R5 running advances", d, 32'h0000_0A00);

        // R4 loads and carry into upper word
        wr(1, 0, 32'h1234_5678);
        wr(1, 1, 32'hFFFF_FE00);
        ticks(1);
        rd(1, 0, d); chk("R4 carry upper", d, 32'h1234_5679);
        rd(1, 1, d); chk("R4 carry lower", d, 32'h0);

        // R6 wrap at maximum
        wr(1, 0, 32'hFFFF_FFFF);
        wr(1, 1, 32'hFFFF_FC00);
        ticks(1);
        rd(1, 0, d); chk("R4 upper masked", d, 32'h7FFF_FFFF);
        rd(1, 1, d); chk("R3 lower max", d, 32'hFFFF_FE00);
        ticks(1);
        rd(1, 0, d); chk("R6 wrap reached", d, 32'h8000_0000);
        rd(1, 1, d); chk("R6 wrap zero", d, 32'h0);
        chk("R8 no irq at wrap", 32'(irq[1]), 32'h0);
        wr(1, 1, 32'h0000_0200);
        rd(1, 0, d); chk("R4 write clears reached", d, 32'h0);
        wr(1, 1, 32'h0000_03FF);
        rd(1, 1, d); chk("R3 low bits zero", d, 32'h0000_0200);

        // R9 forced limit, R10 leave user mode
        wr(1, 3, 32'h0);
        wr(0, 4, 32'h0);
        rd(1, 3, d); chk("R10 run kept", d, 32'h0);
        rd(1, 0, d); chk("R9 forced limit", d, 32'h7FFF_FE00);
        rd(1, 1, d); chk("R10 count after leave", d, 32'h0000_0200);
        ticks(2);
        rd(1, 1, d); chk("R10 counts after leave", d, 32'h0000_0600);

        // random loads on timer 3 in user mode
        wr(0, 4, 32'h4);
        for (int i = 0; i < 40; i++) begin
            logic [30:0] hi;
            logic [22:0] lo;
            int n;
            hi = 31'($urandom);
            lo = 23'($urandom);
            if ($urandom % 4 == 0) hi = 31'h7FFF_FFFF;
            if ($urandom % 3 == 0) lo = 23'h7F_FFFF - 23'($urandom % 8);
            n = int'($urandom % 12);
            wr(3, 0, {1'b0, hi});
            wr(3, 1, {lo, 9'h1FF});
            ticks(n);
            e = user_model(hi, lo, n);
            rd(3, 0, d); chk("R6 random upper", d, e[63:32]);
            rd(3, 1, d); chk("R5 random lower", d, e[31:0]);
            chk("R8 random irq", 32'(irq[3]), 32'h0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule